// File: doc/BRIEF.md
# Asynchronous DRAM Controller with CAS-before-RAS Refresh

This block connects a synchronous host to a one-megabit by one-bit asynchronous DRAM. The host issues a single-bit read or write to a 20-bit word address. The controller drives the multiplexed 10-bit address bus, the row and column strobes, the write enable and the data-in pin. For each request it runs one random-access cycle, using early write for stores. Every timing interval is a whole number of clock cycles set by parameters. The defaults assume a 10 ns clock: a strobe delay of 2 cycles, a row strobe width of 5, a precharge of 4 and a full cycle of 10.

A free-running interval counter raises a refresh request every `REF_PERIOD` cycles. This keeps the rate at or above 512 rows per 8 ms. The pending refresh is served the next time the sequencer is idle. A refresh wins over a waiting host request. A host cycle that has already started always runs to completion. Refresh uses CAS-before-RAS ordering, so no row address is needed.

The request side is a valid/ready channel. The host holds `req_valid`, `req_write`, `req_addr` and `req_wdata` steady until it sees `req_ready` high at a rising clock edge. `req_ready` is low during any access or refresh, and also whenever a refresh is pending. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse that the host must take when it appears, and for reads it carries the sampled bit on `rsp_rdata`.

Top module: `dram_ctrl`

## Requirements
- R1: During and right after reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `rsp_valid` is low, and `req_ready` is high in the first cycle after reset is released.
- R2: An access drives `req_addr[19:10]` on `dram_addr` when the row strobe falls, and drives `req_addr[9:0]` when the column strobe falls.
- R3: In an access, at least `T_RCD` (2) cycles pass between the fall of `dram_ras_n` and the fall of `dram_cas_n`.
- R4: `dram_ras_n` stays low for at least `T_RAS` (5) cycles and high for at least `T_RP` (4) cycles between pulses. Two consecutive row-strobe falls are at least `T_RC` (10) cycles apart.
- R5: `dram_cas_n` stays low for at least `T_CAS` (2) cycles.
- R6: A write (`req_write`=1) drives `dram_we_n` low at least one cycle before the column strobe falls and holds it steady while the column strobe is low. A read keeps `dram_we_n` high.
- R7: Each completed access gives exactly one single-cycle `rsp_valid` pulse. For a read, `rsp_rdata` equals the bit last written to that address, or 0 if the address was never written.
- R8: A refresh lowers `dram_cas_n` at least one cycle before `dram_ras_n` falls, with `dram_we_n` high for the whole refresh.
- R9: Consecutive refreshes start no less than `REF_PERIOD`-16 and no more than `REF_PERIOD`+16 cycles apart, whether the host is idle or busy.
- R10: While a refresh is pending, `req_ready` is low. Refreshes keep occurring even when the host holds `req_valid` high continuously.
- R11: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low while a cycle is in progress. No DRAM access starts without an accepted request, and every accepted request gets exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address; upper half row, lower half column |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 1 | Read data, valid with `rsp_valid` |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_di | output | 1 | Data to the DRAM data-in pin |
| dram_do | input | 1 | DRAM data-out pin, high impedance when not reading |

## Verification
The hardest case is a refresh that falls due while the host is saturating the port. To pass, the refresh must take the idle slot between two back-to-back accesses without cutting either one short. The bench creates this by streaming several hundred requests with `req_valid` never released, which spans several refresh intervals. A cycle-counting DRAM model checks every strobe edge against the minimum widths and the refresh spacing. It also checks the latched row and column against the request queue, and it keeps a memory whose contents come back through reads.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RCD,
    ST_CAS,
    ST_PRE,
    ST_RF_CAS,
    ST_RF_RAS,
    ST_RF_PRE
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dramc_refresh_timer.sv
module dramc_refresh_timer #(
  parameter int PERIOD = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end

  AST_ACK_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    ack |-> pending); // R9
endmodule

// File: rtl/dramc_sequencer.sv
module dramc_sequencer
  import dramc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DA_W   = 10,
  parameter int T_RCD  = 2,
  parameter int T_RAS  = 5,
  parameter int T_RP   = 4,
  parameter int T_RC   = 10,
  parameter int T_CAS  = 2,
  parameter int T_CAC  = 2,
  parameter int T_CSR  = 1,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_pending,
  output logic              ref_ack,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [DA_W-1:0]   dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_di,
  input  logic              dram_do
);
  localparam int CAS_HOLD = imax(imax(T_CAS, T_CAC), T_RAS - T_RCD);
  localparam int PRE_LEN  = imax(T_RP, T_RC - (T_RCD + CAS_HOLD));
  localparam int RF_PRE   = imax(T_RP, T_RC - T_RAS);

  seq_state_e        state, nxt;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [DA_W-1:0]   row_q, col_q, row_nx, col_nx;
  logic              wr_q, wr_nx, take;

  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign row_nx    = take ? req_addr[ADDR_W-1:DA_W] : row_q;
  assign col_nx    = take ? req_addr[DA_W-1:0]      : col_q;
  assign wr_nx     = take ? req_write               : wr_q;

  always_comb begin
    nxt     = state;
    cnt_nxt = (cnt == '0) ? '0 : cnt - 1'b1;
    ref_ack = 1'b0;
    take    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ref_pending) begin
          nxt     = ST_RF_CAS;
          cnt_nxt = CNT_W'(T_CSR - 1);
          ref_ack = 1'b1;
        end else if (req_valid) begin
          nxt     = ST_SETUP;
          cnt_nxt = '0;
          take    = 1'b1;
        end
      end
      ST_SETUP: begin
        nxt     = ST_RCD;
        cnt_nxt = CNT_W'(T_RCD - 1);
      end
      ST_RCD: if (cnt == '0) begin
        nxt     = ST_CAS;
        cnt_nxt = CNT_W'(CAS_HOLD - 1);
      end
      ST_CAS: if (cnt == '0) begin
        nxt     = ST_PRE;
        cnt_nxt = CNT_W'(PRE_LEN - 1);
      end
      ST_PRE: if (cnt == '0) nxt = ST_IDLE;
      ST_RF_CAS: if (cnt == '0) begin
        nxt     = ST_RF_RAS;
        cnt_nxt = CNT_W'(T_RAS - 1);
      end
      ST_RF_RAS: if (cnt == '0) begin
        nxt     = ST_RF_PRE;
        cnt_nxt = CNT_W'(RF_PRE - 1);
      end
      ST_RF_PRE: if (cnt == '0) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so each pin comes straight off a flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      row_q      <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      dram_di    <= 1'b0;
      dram_addr  <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= 1'b0;
    end else begin
      state      <= nxt;
      cnt        <= cnt_nxt;
      row_q      <= row_nx;
      col_q      <= col_nx;
      wr_q       <= wr_nx;
      if (take) dram_di <= req_wdata;
      dram_addr  <= (nxt == ST_CAS) ? col_nx : row_nx;
      dram_ras_n <= !(nxt inside {ST_RCD, ST_CAS, ST_RF_RAS});
      dram_cas_n <= !(nxt inside {ST_CAS, ST_RF_CAS, ST_RF_RAS});
      dram_we_n  <= !((nxt inside {ST_SETUP, ST_RCD, ST_CAS}) && wr_nx);
      rsp_valid  <= (state == ST_CAS) && (cnt == '0);
      if ((state == ST_CAS) && (cnt == '0))
        rsp_rdata <= wr_q ? 1'b0 : dram_do;
    end
  end

  // Pulse-age counters used only by the checks below.
  logic [CNT_W-1:0] ras_age, cas_age;
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_age <= '0;
      cas_age <= '0;
    end else begin
      ras_age <= dram_ras_n ? '0 : ((ras_age == '1) ? ras_age : ras_age + 1'b1);
      cas_age <= dram_cas_n ? '0 : ((cas_age == '1) ? cas_age : cas_age + 1'b1);
    end
  end

  AST_RCD_MIN: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_ras_n && !$past(dram_ras_n)) |-> (ras_age >= CNT_W'(T_RCD))); // R3
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> (ras_age >= CNT_W'(T_RAS))); // R4
  AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas_n) |-> (cas_age >= CNT_W'(T_CAS))); // R5
  AST_WE_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && !$past(dram_cas_n)) |-> $stable(dram_we_n)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R7
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_ras_n) && !dram_cas_n) |-> !$past(dram_cas_n)); // R8
  AST_REFRESH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && dram_ras_n) |-> dram_we_n); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (dram_ras_n && dram_cas_n)); // R11
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter  int ADDR_W     = 20,
  parameter  int T_RCD      = 2,
  parameter  int T_RAS      = 5,
  parameter  int T_RP       = 4,
  parameter  int T_RC       = 10,
  parameter  int T_CAS      = 2,
  parameter  int T_CAC      = 2,
  parameter  int T_CSR      = 1,
  parameter  int REF_PERIOD = 1560,
  localparam int DA_W       = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [DA_W-1:0]   dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_di,
  input  logic              dram_do
);
  logic ref_pending, ref_ack;

  dramc_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .ack     (ref_ack),
    .pending (ref_pending)
  );

  dramc_sequencer #(
    .ADDR_W(ADDR_W), .DA_W(DA_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RC(T_RC), .T_CAS(T_CAS), .T_CAC(T_CAC), .T_CSR(T_CSR), .CNT_W(8)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .ref_pending (ref_pending),
    .ref_ack     (ref_ack),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_di     (dram_di),
    .dram_do     (dram_do)
  );

  AST_REF_BLOCKS_HOST: assert property (@(posedge clk) disable iff (rst)
    ref_pending |-> !req_ready); // R10
endmodule

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
  localparam int T_RCD = 2, T_RAS = 5, T_RP = 4, T_RC = 10, T_CASMIN = 2, T_CAC = 2;
  localparam int REF = 1560;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, req_valid, req_ready, req_write, req_wdata;
  logic [19:0] req_addr;
  logic        rsp_valid, rsp_rdata;
  logic [9:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_di;
  logic        drv_en = 1'b0, drv_val = 1'b0;
  wire         dram_do = drv_en ? drv_val : 1'bz;

  dram_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_di(dram_di), .dram_do(dram_do)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct { bit wr; bit d; } exp_t;
  exp_t exp_q[$];
  int   addr_q[$];
  bit   shadow[int];

  function automatic bit shadow_rd(input int a);
    return shadow.exists(a) ? shadow[a] : 1'b0;
  endfunction

  // Behavioural DRAM: samples pins on the falling clock edge and counts cycles.
  bit pr_ras = 1, pr_cas = 1, pr_we = 1, cbr = 0, rd_act = 0;
  int ras_lo = 0, ras_hi = 1000, cas_lo = 0, cyc = 0;
  int last_ras_fall = -1, last_cbr = -1, ref_count = 0;
  logic [9:0] row_l = '0;
  bit mm[int];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (pr_ras && !dram_ras_n) begin
        chk(ras_hi >= T_RP, "R4", "precharge cycles", ras_hi, T_RP);
        if (last_ras_fall >= 0)
          chk(cyc - last_ras_fall >= T_RC, "R4", "row cycle", cyc - last_ras_fall, T_RC);
        last_ras_fall = cyc;
        if (!dram_cas_n) begin
          cbr = 1;
          chk(!pr_cas, "R8", "cas low before ras", int'(pr_cas), 0);
          chk(dram_we_n, "R8", "we during refresh", int'(dram_we_n), 1);
          if (last_cbr >= 0) begin
            chk(cyc - last_cbr <= REF + 16, "R9", "refresh gap max", cyc - last_cbr, REF + 16);
            chk(cyc - last_cbr >= REF - 16, "R9", "refresh gap min", cyc - last_cbr, REF - 16);
          end
          last_cbr = cyc;
          ref_count++;
        end else begin
          cbr = 0;
          row_l = dram_addr;
        end
      end
      if (!pr_ras && dram_ras_n)
        chk(ras_lo >= T_RAS, "R4", "ras width", ras_lo, T_RAS);
      if (pr_cas && !dram_cas_n && !dram_ras_n && !cbr) begin
        chk(ras_lo >= T_RCD, "R3", "ras to cas", ras_lo, T_RCD);
        if (addr_q.size() == 0) begin
          chk(0, "R11", "access without request", 1, 0);
        end else begin
          int ea;
          bit ew;
          ea = addr_q.pop_front();
          ew = exp_q.size() > 0 ? exp_q[0].wr : 1'b0;
          chk(int'({row_l, dram_addr}) == ea, "R2", "row/col address", int'({row_l, dram_addr}), ea);
          chk(dram_we_n == !ew, "R6", "we level", int'(dram_we_n), int'(!ew));
          if (ew) chk(!pr_we, "R6", "we before cas", int'(pr_we), 0);
          if (!dram_we_n) mm[int'({row_l, dram_addr})] = dram_di;
          else rd_act = 1;
        end
      end
      if (!pr_cas && dram_cas_n) begin
        chk(cas_lo >= T_CASMIN, "R5", "cas width", cas_lo, T_CASMIN);
        rd_act = 0;
      end
      ras_lo = dram_ras_n ? 0 : ras_lo + 1;
      ras_hi = dram_ras_n ? ras_hi + 1 : 0;
      cas_lo = dram_cas_n ? 0 : cas_lo + 1;
      drv_en = rd_act && !dram_cas_n && (cas_lo >= T_CAC);
      drv_val = mm.exists(int'({row_l, dram_addr})) ? mm[int'({row_l, dram_addr})] : 1'b0;
      pr_ras = dram_ras_n;
      pr_cas = dram_cas_n;
      pr_we  = dram_we_n;
    end
  end

  // Scoreboard monitor.
  bit prev_rsp = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        chk(!prev_rsp, "R7", "single-cycle done", int'(prev_rsp), 0);
        if (exp_q.size() == 0) begin
          chk(0, "R11", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (!e.wr) chk(rsp_rdata === e.d, "R7", "read data", int'(rsp_rdata), int'(e.d));
          else       chk(1, "R7", "write done", 1, 1);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic host_op(input bit w, input int a, input bit d);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a[19:0];
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_q.push_back('{w, w ? d : shadow_rd(a)});
    addr_q.push_back(a);
    if (w) shadow[a] = d;
    @(posedge clk);
    @(negedge clk);
    chk(!req_ready, "R11", "ready low after accept", int'(req_ready), 0);
  endtask

  task automatic go_idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int pat_addr(input int i);
    return (i * 32'h2F3A7 + 13) & 32'hFFFFF;
  endfunction

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int refs0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = 1'b0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes idle in reset",
        int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
    chk(!rsp_valid, "R1", "no done in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
    chk(dram_ras_n && dram_cas_n, "R1", "strobes idle after reset",
        int'({dram_ras_n, dram_cas_n}), 3);

    // Corner addresses: row and column extremes.
    host_op(1, 32'h00000, 1); host_op(1, 32'hFFFFF, 1);
    host_op(1, 32'h003FF, 0); host_op(1, 32'hFFC00, 1);
    host_op(1, 32'h003FE, 1);
    go_idle(3);
    host_op(0, 32'h00000, 0); host_op(0, 32'hFFFFF, 0);
    host_op(0, 32'h003FF, 0); host_op(0, 32'hFFC00, 0);
    host_op(0, 32'h003FE, 0); host_op(0, 32'h55555, 0);
    host_op(1, 32'hFFFFF, 0); host_op(0, 32'hFFFFF, 0);
    go_idle(5);

    // Pattern writes then reads with gaps.
    for (int i = 0; i < 24; i++) host_op(1, pat_addr(i), ^pat_addr(i) ^ i[0]);
    go_idle(7);
    for (int i = 0; i < 24; i++) begin
      host_op(0, pat_addr(i), 0);
      if (i % 5 == 0) go_idle(i % 3 + 1);
    end

    // Saturating stream: req_valid never drops, refresh must still get in.
    refs0 = ref_count;
    for (int i = 0; i < 420; i++) begin
      if (i % 3 == 0) host_op(1, pat_addr(i + 100), i[1]);
      else            host_op(0, pat_addr((i * 7) % 124), 0);
    end
    go_idle(1);
    chk(ref_count - refs0 >= 2, "R10", "refreshes under full load", ref_count - refs0, 2);
    for (int k = 0; k < 100 && exp_q.size() != 0; k++) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "all requests answered", exp_q.size(), 0);

    // Idle host: refresh continues on its own.
    refs0 = ref_count;
    go_idle(2 * REF + 50);
    chk(ref_count - refs0 >= 2, "R9", "refreshes while idle", ref_count - refs0, 2);
    chk(addr_q.size() == 0, "R11", "no stray accesses", addr_q.size(), 0);
    summary();
    $finish;
  end
endmodule